// File: doc/BRIEF.md
# Sixteen-Channel Event Trigger Capture

This block gathers trigger signals for a beam-synchronous event system. Each of its sixteen channels watches one external input line. A rising edge on an enabled channel, or a software trigger, sets a request flag for that channel. The flag stays set until an external polling scanner takes it. The scanner steps through channel indices at its own rate. For the index it offers, it sees whether a request is waiting, and it acknowledges the request to take it.

A scanner that polls more slowly than the inputs arrive loses requests. When a channel receives a new request while its previous one is still waiting, the block records an overrun bit for that channel. Software reads the overrun bits a byte at a time, and each read clears the bits it returned. An overrun bit on a channel whose interrupt is enabled holds the module interrupt line high.

Software reaches four 16-bit control words through a byte-wide register port: channel enable, interrupt enable, trigger and overrun. Each word is split into a high byte and a low byte. Address decoding for the wider bus and interrupt vector delivery are handled elsewhere.

Top module: `evtInCapture`

## Requirements
- R1: After reset, every register reads 0, no channel has a request pending, and `irq` is low.
- R2: `regAddr[2:1]` selects the word: 0 is channel enable, 1 is interrupt enable, 2 is trigger and 3 is overrun. `regAddr[0]`=0 selects the high byte (channels 15..8, channel 8 in data bit 0) and `regAddr[0]`=1 selects the low byte (channels 7..0). A write changes only the addressed byte. The enable and interrupt enable words read back the value written.
- R3: A channel whose enable bit is 0 never becomes pending, whatever happens on its input or trigger bit.
- R4: On an enabled channel, a 0-to-1 transition of `sigIn` that is set up before clock edge k makes the channel pending after edge k+2. A level held high produces no further requests.
- R5: Writing a trigger byte makes every enabled channel whose data bit is 1 pending at the same edge. The trigger word always reads 0.
- R6: `scanPending` shows the pending bit of channel `scanIdx`. Asserting `scanAck` clears that bit at the clock edge.
- R7: A new request on a channel that is already pending and is not being acknowledged sets the channel's overrun bit. The channel stays pending.
- R8: A request that arrives in the same cycle as the acknowledge of that channel leaves the channel pending and sets no overrun bit.
- R9: A read of an overrun byte returns the latched bits and clears them at that edge. The other byte is left unchanged. An overrun that arises in the same cycle as the read remains set.
- R10: `irq` is high exactly while some channel has both its overrun bit and its interrupt enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigIn | input | 16 | Asynchronous external trigger lines, one per channel |
| regAddr | input | 3 | Register byte select: word in bits 2:1, half in bit 0 |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; clears overrun bits on an overrun read |
| regWrData | input | 8 | Register write byte |
| regRdData | output | 8 | Register read byte, combinational from `regAddr` |
| scanIdx | input | 4 | Channel index offered by the scanner |
| scanAck | input | 1 | Scanner takes the request of channel `scanIdx` |
| scanPending | output | 1 | Request of channel `scanIdx` is waiting |
| irq | output | 1 | Module interrupt request |

## Verification
Directed patterns come first:
- A single software trigger followed by an acknowledge shows the latch-and-take path.
- A held-high input line separates edge detection from level sensing, and shows the three-edge latency.
- A second trigger with no acknowledge between the two triggers is an overrun.
- A trigger that lands in the same cycle as its own acknowledge is not an overrun.
- A masked channel that receives both an edge and a trigger stays silent.

After these, seeded random traffic mixes input toggles, register writes and reads, and scanner acknowledges on arbitrary channels. This exposes collisions between clear-on-read and new overruns, and byte-half selection errors, against a cycle model of the requirements.

// File: rtl/evtInPkg.sv
`timescale 1ns/1ps
package evtInPkg;
  localparam int NUM_CH  = 16;
  localparam int BYTE_W  = 8;

  // register word codes carried in regAddr[2:1]
  localparam logic [1:0] SEL_ENABLE = 2'd0;
  localparam logic [1:0] SEL_IRQEN  = 2'd1;
  localparam logic [1:0] SEL_TRIG   = 2'd2;
  localparam logic [1:0] SEL_OVRN   = 2'd3;

  typedef struct packed {
    logic              wrEnable;
    logic              wrIrqEn;
    logic              wrTrig;
    logic              rdOvrn;
    logic              hiHalf;
    logic [1:0]        regSel;
    logic [BYTE_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/evtInCtrl.sv
`timescale 1ns/1ps
module evtInCtrl
  import evtInPkg::*;
(
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output regStrobe_t        strb
);
  logic [1:0] sel;
  assign sel = regAddr[2:1];

  always_comb begin
    strb.regSel   = sel;
    strb.hiHalf   = ~regAddr[0];
    strb.data     = regWrData;
    strb.wrEnable = regWr && (sel == SEL_ENABLE);
    strb.wrIrqEn  = regWr && (sel == SEL_IRQEN);
    strb.wrTrig   = regWr && (sel == SEL_TRIG);
    strb.rdOvrn   = regRd && (sel == SEL_OVRN);
  end
endmodule

// File: rtl/evtInSync.sv
`timescale 1ns/1ps
module evtInSync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] stage1, stage2, lastLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= '0;
      stage2  <= '0;
      lastLvl <= '0;
    end else begin
      stage1  <= din;
      stage2  <= stage1;
      lastLvl <= stage2;
    end
  end

  assign rise = stage2 & ~lastLvl;
endmodule

// File: rtl/evtInDatapath.sv
`timescale 1ns/1ps
module evtInDatapath
  import evtInPkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NCH-1:0]          rise,
  input  regStrobe_t              strb,
  input  logic [$clog2(NCH)-1:0]  scanIdx,
  input  logic                    scanAck,
  output logic                    scanPending,
  output logic [BYTE_W-1:0]       rdData,
  output logic                    irq,
  output logic [NCH-1:0]          pendVec,
  output logic [NCH-1:0]          errVec,
  output logic [NCH-1:0]          enVec
);
  localparam int IDX_W = $clog2(NCH);
  localparam int HALF  = NCH / 2;

  logic [NCH-1:0] enQ, ienQ, errQ, pendQ;
  logic [NCH-1:0] halfMask, wideData, trigPulse, req, overrun, errClr;

  assign halfMask  = strb.hiHalf ? {{HALF{1'b1}}, {HALF{1'b0}}}
                                 : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign wideData  = {2{strb.data}};
  assign trigPulse = strb.wrTrig ? (wideData & halfMask) : '0;
  assign req       = (rise | trigPulse) & enQ;
  assign errClr    = strb.rdOvrn ? halfMask : '0;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic ackHit;
    assign ackHit      = scanAck && (scanIdx == IDX_W'(ch));
    assign overrun[ch] = req[ch] && pendQ[ch] && !ackHit;

    always_ff @(posedge clk) begin
      if (!rstN)          pendQ[ch] <= 1'b0;
      else if (ackHit)    pendQ[ch] <= req[ch];
      else if (req[ch])   pendQ[ch] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      ienQ <= '0;
      errQ <= '0;
    end else begin
      if (strb.wrEnable) enQ  <= (enQ  & ~halfMask) | (wideData & halfMask);
      if (strb.wrIrqEn)  ienQ <= (ienQ & ~halfMask) | (wideData & halfMask);
      errQ <= (errQ & ~errClr) | overrun;
    end
  end

  function automatic logic [BYTE_W-1:0] pickHalf(input logic [NCH-1:0] v, input logic hi);
    return hi ? v[NCH-1:HALF] : v[HALF-1:0];
  endfunction

  always_comb begin
    case (strb.regSel)
      SEL_ENABLE: rdData = pickHalf(enQ, strb.hiHalf);
      SEL_IRQEN:  rdData = pickHalf(ienQ, strb.hiHalf);
      SEL_OVRN:   rdData = pickHalf(errQ, strb.hiHalf);
      default:    rdData = '0;
    endcase
  end

  assign irq         = |(errQ & ienQ);
  assign scanPending = pendQ[scanIdx];
  assign pendVec     = pendQ;
  assign errVec      = errQ;
  assign enVec       = enQ;
endmodule

// File: rtl/evtInCapture.sv
`timescale 1ns/1ps
module evtInCapture
  import evtInPkg::*;
#(
  parameter int NCH   = NUM_CH,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    sigIn,
  input  logic [2:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic [IDX_W-1:0]  scanIdx,
  input  logic              scanAck,
  output logic              scanPending,
  output logic              irq
);
  regStrobe_t     strb;
  logic [NCH-1:0] rise;
  logic [NCH-1:0] pendVec, errVec, enVec;

  evtInCtrl u_ctrl (
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb)
  );

  evtInSync #(.WIDTH(NCH)) u_sync (
    .clk(clk), .rstN(rstN), .din(sigIn), .rise(rise)
  );

  evtInDatapath #(.NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .rise(rise), .strb(strb),
    .scanIdx(scanIdx), .scanAck(scanAck), .scanPending(scanPending),
    .rdData(regRdData), .irq(irq),
    .pendVec(pendVec), .errVec(errVec), .enVec(enVec)
  );
endmodule

// File: rtl/evtInCapture_chk.sv
`timescale 1ns/1ps
module evtInCapture_chk #(
  parameter int NCH   = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic             regRd,
  input logic [IDX_W-1:0] scanIdx,
  input logic             scanAck,
  input logic             irq,
  input logic [NCH-1:0]   pendVec,
  input logic [NCH-1:0]   errVec,
  input logic [NCH-1:0]   enVec
);
  // R3: a channel can only turn pending if it was enabled the cycle before
  a_r3_masked_idle: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & ~$past(pendVec) & ~$past(enVec)) == '0);

  // R7: a fresh overrun bit needs a request already waiting
  a_r7_overrun_needs_pend: assert property (@(posedge clk) disable iff (!rstN)
    (errVec & ~$past(errVec) & ~$past(pendVec)) == '0);

  // R8: the acknowledged channel never gains an overrun at that edge
  a_r8_ack_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    scanAck |=> !(errVec[$past(scanIdx)] && !$past(errVec[scanIdx])));

  // R10: without register traffic an active interrupt persists
  a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !regWr && !regRd) |=> irq);
endmodule

bind evtInCapture evtInCapture_chk #(.NCH(NCH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
  .scanIdx(scanIdx), .scanAck(scanAck), .irq(irq),
  .pendVec(pendVec), .errVec(errVec), .enVec(enVec)
);

// File: tb/sim_evtInCapture.sv
`timescale 1ns/1ps
module sim_evtInCapture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] sigIn = '0;
  logic [2:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [3:0]  scanIdx = '0;
  logic        scanAck = 1'b0;
  logic        scanPending;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // model state derived from the requirements
  logic [15:0] mS1 = '0, mS2 = '0, mPrev = '0;
  logic [15:0] mPend = '0, mErr = '0, mEn = '0, mIen = '0;
  logic [7:0]  lastRd;

  evtInCapture u0 (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .regWrData(regWrData),
    .regRdData(regRdData), .scanIdx(scanIdx), .scanAck(scanAck),
    .scanPending(scanPending), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] hMask(input logic [2:0] a);
    return a[0] ? 16'h00FF : 16'hFF00;
  endfunction

  function automatic logic [7:0] pick(input logic [15:0] v, input logic [2:0] a);
    return a[0] ? v[7:0] : v[15:8];
  endfunction

  function automatic logic [7:0] expRd(input logic [2:0] a);
    case (a[2:1])
      2'd0: return pick(mEn, a);
      2'd1: return pick(mIen, a);
      2'd3: return pick(mErr, a);
      default: return 8'h00;
    endcase
  endfunction

  // one clock: inputs already driven after a falling edge
  task automatic step();
    logic [15:0] rise, tp, req, hm, nPend, nErr;
    #1;
    lastRd = regRdData;
    chk("R6 scanPending", scanPending, mPend[scanIdx]);
    chk("R10 irq", irq, |(mErr & mIen));
    chk((regAddr[2:1] == 2'd3) ? "R9 overrun read" : "R2 read", regRdData, expRd(regAddr));
    hm   = hMask(regAddr);
    rise = mS2 & ~mPrev;
    tp   = (regWr && regAddr[2:1] == 2'd2) ? ({2{regWrData}} & hm) : '0;
    req  = (rise | tp) & mEn;
    nPend = mPend;
    nErr  = (regRd && regAddr[2:1] == 2'd3) ? (mErr & ~hm) : mErr;
    for (int c = 0; c < 16; c++) begin
      if (scanAck && scanIdx == c[3:0]) nPend[c] = req[c];
      else if (req[c]) begin
        if (mPend[c]) nErr[c] = 1'b1;
        nPend[c] = 1'b1;
      end
    end
    if (regWr && regAddr[2:1] == 2'd0) mEn  = (mEn  & ~hm) | ({2{regWrData}} & hm);
    if (regWr && regAddr[2:1] == 2'd1) mIen = (mIen & ~hm) | ({2{regWrData}} & hm);
    mPend = nPend;
    mErr  = nErr;
    mPrev = mS2;
    mS2   = mS1;
    mS1   = sigIn;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    regWr = 0; regRd = 0; scanAck = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWr = 1; regRd = 0;
    step();
    regWr = 0;
  endtask

  task automatic rd(input logic [2:0] a);
    regAddr = a; regRd = 1; regWr = 0;
    step();
    regRd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      regAddr = a[2:0];
      #1 chk("R1 reset read", regRdData, 0);
    end
    for (int i = 0; i < 16; i++) begin
      scanIdx = i[3:0];
      #1 chk("R1 reset pending", scanPending, 0);
    end
    chk("R1 reset irq", irq, 0);

    // R2 register access
    wr(3'b000, 8'hFF); wr(3'b001, 8'hFF); wr(3'b011, 8'h0F);
    regAddr = 3'b000; #1 chk("R2 enable hi", regRdData, 8'hFF);
    regAddr = 3'b011; #1 chk("R2 irq enable lo", regRdData, 8'h0F);
    regAddr = 3'b010; #1 chk("R2 irq enable hi untouched", regRdData, 8'h00);

    // R5 software trigger, trigger word reads 0
    scanIdx = 4'd0;
    wr(3'b101, 8'h01);
    chk("R5 trigger sets pending", scanPending, 1);
    regAddr = 3'b101; #1 chk("R5 trigger reads zero", regRdData, 0);

    // R6 acknowledge clears
    scanAck = 1; step(); scanAck = 0;
    chk("R6 ack clears", scanPending, 0);

    // R4 edge latency and no retrigger on level
    scanIdx = 4'd3; sigIn[3] = 1'b1;
    step(); step();
    chk("R4 not yet pending", scanPending, 0);
    step();
    chk("R4 pending after edge", scanPending, 1);
    scanAck = 1; step(); scanAck = 0;
    repeat (4) step();
    chk("R4 level no retrigger", scanPending, 0);
    sigIn[3] = 1'b0; repeat (3) step();

    // R7 overrun, R10 irq, R9 clear-on-read
    wr(3'b101, 8'h08);
    wr(3'b101, 8'h08);
    chk("R7 still pending", scanPending, 1);
    chk("R10 irq on overrun", irq, 1);
    rd(3'b111);
    chk("R7 overrun bit", lastRd, 8'h08);
    chk("R10 irq after clear", irq, 0);
    rd(3'b111);
    chk("R9 cleared by read", lastRd, 8'h00);

    // R8 request coinciding with ack
    scanAck = 1; wr(3'b101, 8'h08); scanAck = 0;
    chk("R8 still pending", scanPending, 1);
    rd(3'b111);
    chk("R8 no overrun", lastRd, 8'h00);
    scanAck = 1; step(); scanAck = 0;

    // R3 masked channel
    wr(3'b001, 8'hDF);
    scanIdx = 4'd5;
    wr(3'b101, 8'h20);
    sigIn[5] = 1'b1; repeat (4) step(); sigIn[5] = 1'b0;
    wr(3'b101, 8'h20);
    chk("R3 masked not pending", scanPending, 0);
    rd(3'b111);
    chk("R3 masked no overrun", lastRd, 8'h00);

    // seeded random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      for (int c = 0; c < 16; c++)
        if (($urandom % 100) < 4) sigIn[c] = ~sigIn[c];
      regWr = 0; regRd = 0;
      r = $urandom % 100;
      regAddr = 3'($urandom);
      regWrData = 8'($urandom);
      if (r < 12) regWr = 1;
      else if (r < 22) regRd = 1;
      else if (r < 28) begin regRd = 1; regAddr[2:1] = 2'd3; end
      scanIdx = 4'($urandom);
      scanAck = (($urandom % 100) < 35);
      step();
    end
    idle();
    step();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule